// File: doc/BRIEF.md
# Bounded-Loop Row Accumulator

This block walks a square array of signed 32-bit words, one element per clock, in row-major order. For each row it keeps a running sum and writes the updated sum to the output slot for that row after every element. The sum is cleared at the first column of each row, so the final write for a row leaves the sum of that row's processed elements in its slot.

Two 4-bit unsigned size inputs set how many rows and how many columns to process. Both are captured when `start` is accepted. Both loops are fixed-range counters with a maximum of 8. A loop ends after the iteration whose index equals the size minus one, or after index 7. A size of 0, or any size above 8, therefore never matches an index, and that loop runs all 8 iterations.

The read port addresses an external synchronous memory. The address and `rd_en` come from registers, and the memory must return the word on `rd_data` in the clock cycle after a request. The write port carries one registered write per element into the row results. Neither port has back-pressure: the block issues one read every cycle while it scans, and any write it presents must be taken in that cycle. `busy` and `done` are plain status pins.

Top module: `rowacc_top`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en` and `wr_en` are all low, and they stay low until `start` is seen.
- R2: When `start` is high and `busy` is low at a clock edge, the sizes are captured. In the next cycle `rd_en` is high with row 0 and column 0, and `busy` is high.
- R3: Reads are issued in row-major order (column inner, row outer), one address per clock, with no idle cycle between the first and the last read.
- R4: The running sum restarts from zero at column 0 of every row. Each write carries the 32-bit two's-complement wrapping sum of that row's elements up to and including the current column.
- R5: Each write goes to the slot numbered by the current row (`wr_idx` = row). It appears exactly two cycles after the read request for the same element.
- R6: The column loop ends after the column whose index equals the column size minus one. The row loop ends in the same way using the row size. The block processes rows × columns elements in total.
- R7: A size of 0, or any size from 9 to 15, makes that loop run all 8 iterations.
- R8: `done` is high for exactly one cycle, in the cycle after the final write. `busy` stays high through that cycle and is low in the following cycle.
- R9: `start` is ignored while `busy` is high. Sizes or pulses given during a run change neither that run's reads and writes nor its length, and no new run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| row_size | input | 4 | Number of rows to process (0 or >8 means 8) |
| col_size | input | 4 | Number of columns to process (0 or >8 means 8) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last write |
| rd_en | output | 1 | Read request to the input memory |
| rd_row | output | 3 | Read row address |
| rd_col | output | 3 | Read column address |
| rd_data | input | 32 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Write strobe to the row results |
| wr_idx | output | 3 | Row result slot being written |
| wr_data | output | 32 | Running row sum |

## Verification
The hardest case to reach from the ports is a loop end that comes from the fixed maximum rather than from a size match. In that case the size-minus-one compare wraps to 15 or points past 7, and only the index-7 exit stops the scan. The stimulus drives sizes 0, 9 and 12 along with exact sizes. It then compares the full logged address and write streams, with their cycle stamps, against a row-major model. A second hard case is a start request during a run. The bench changes both sizes and holds `start` high over several busy cycles, then checks that the logged run matches the sizes captured first.

// File: rtl/rowacc_pkg.sv
package rowacc_pkg;
  localparam int unsigned DIM_DEFAULT = 8;
  localparam int unsigned DW_DEFAULT  = 32;

  // Position tags travelling with each read request.
  typedef struct packed {
    logic first;  // column 0 of a row: restart the sum
    logic last;   // final element of the whole scan
  } pos_tag_t;
endpackage

// File: rtl/rowacc_seq.sv
module rowacc_seq
  import rowacc_pkg::*;
#(
  parameter int unsigned DIM = DIM_DEFAULT,
  localparam int unsigned IW = $clog2(DIM),
  localparam int unsigned CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] row_size,
  input  logic [CW-1:0] col_size,
  input  logic          done_in,
  output logic          busy,
  output logic          rd_en,
  output logic [IW-1:0] rd_row,
  output logic [IW-1:0] rd_col,
  output pos_tag_t      rd_tag
);
  logic [CW-1:0] row_lim, col_lim;
  logic          col_end, row_end;

  // Loop exit: index hits the fixed ceiling, or equals size-1.
  // Size 0 gives size-1 = all ones, which no 3-bit index reaches.
  function automatic logic at_end(input logic [IW-1:0] idx, input logic [CW-1:0] lim);
    return (idx == IW'(DIM - 1)) || ({1'b0, idx} == (lim - CW'(1)));
  endfunction

  always_comb begin
    col_end = at_end(rd_col, col_lim);
    row_end = at_end(rd_row, row_lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_en   <= 1'b0;
      rd_row  <= '0;
      rd_col  <= '0;
      rd_tag  <= '0;
      row_lim <= '0;
      col_lim <= '0;
    end else begin
      if (busy && done_in) busy <= 1'b0;
      if (!busy && start) begin
        busy        <= 1'b1;
        row_lim     <= row_size;
        col_lim     <= col_size;
        rd_en       <= 1'b1;
        rd_row      <= '0;
        rd_col      <= '0;
        rd_tag.first <= 1'b1;
        rd_tag.last  <= at_end('0, row_size) && at_end('0, col_size);
      end else if (rd_en) begin
        if (col_end) begin
          if (row_end) begin
            rd_en  <= 1'b0;
            rd_tag <= '0;
          end else begin
            rd_row       <= rd_row + IW'(1);
            rd_col       <= '0;
            rd_tag.first <= 1'b1;
            rd_tag.last  <= at_end(rd_row + IW'(1), row_lim) && at_end('0, col_lim);
          end
        end else begin
          rd_col       <= rd_col + IW'(1);
          rd_tag.first <= 1'b0;
          rd_tag.last  <= row_end && at_end(rd_col + IW'(1), col_lim);
        end
      end
    end
  end

  // R3: reads run back to back until the final element
  a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_tag.last |=> rd_en);
  // R6: the final element ends the scan
  a_r6_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_tag.last |=> !rd_en);
  // R9: captured sizes hold for the whole run
  a_r9_limits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(row_lim) && $stable(col_lim));
  // R3: every read belongs to a run
  a_r3_read_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
endmodule

// File: rtl/rowacc_sum.sv
module rowacc_sum
  import rowacc_pkg::*;
#(
  parameter int unsigned DIM = DIM_DEFAULT,
  parameter int unsigned DW  = DW_DEFAULT,
  localparam int unsigned IW = $clog2(DIM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [IW-1:0] req_row,
  input  pos_tag_t      req_tag,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  // Stage aligned with the memory's one-cycle read latency.
  logic          vld_q;
  logic [IW-1:0] row_q;
  pos_tag_t      tag_q;
  logic [DW-1:0] acc;
  logic [DW-1:0] sum;
  logic          wr_last;

  always_comb sum = (tag_q.first ? '0 : acc) + rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      row_q   <= '0;
      tag_q   <= '0;
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      wr_last <= 1'b0;
      done    <= 1'b0;
    end else begin
      vld_q <= req_vld;
      row_q <= req_row;
      tag_q <= req_tag;
      wr_en <= vld_q;
      wr_last <= vld_q && tag_q.last;
      if (vld_q) begin
        acc     <= sum;
        wr_idx  <= row_q;
        wr_data <= sum;
      end
      done <= wr_en && wr_last;
    end
  end

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: no write in the done cycle
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);
endmodule

// File: rtl/rowacc_top.sv
module rowacc_top
  import rowacc_pkg::*;
#(
  parameter int unsigned DIM = DIM_DEFAULT,
  parameter int unsigned DW  = DW_DEFAULT,
  localparam int unsigned IW = $clog2(DIM),
  localparam int unsigned CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] row_size,
  input  logic [CW-1:0] col_size,
  output logic          busy,
  output logic          done,
  output logic          rd_en,
  output logic [IW-1:0] rd_row,
  output logic [IW-1:0] rd_col,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data
);
  pos_tag_t tag;

  rowacc_seq #(.DIM(DIM)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .row_size(row_size), .col_size(col_size), .done_in(done),
    .busy(busy), .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col), .rd_tag(tag)
  );

  rowacc_sum #(.DIM(DIM), .DW(DW)) u_sum (
    .clk(clk), .rst_n(rst_n), .req_vld(rd_en), .req_row(rd_row), .req_tag(tag),
    .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
  );

  // R5: each read request produces a write two cycles later
  a_r5_write_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ##2 wr_en);
  // R8: done only inside a run
  a_r8_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R1: idle block issues nothing
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en && !done);
endmodule

// File: tb/tb_rowacc_top.sv
module tb_rowacc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  row_size = '0, col_size = '0;
  logic        busy, done, rd_en, wr_en;
  logic [2:0]  rd_row, rd_col, wr_idx;
  logic [31:0] rd_data = '0;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] mem [8][8];

  int n_rd, n_wr, n_done;
  int rd_cyc [64]; int rd_r [64]; int rd_c [64];
  int wr_cyc [64]; int wr_i [64]; logic [31:0] wr_v [64];
  int done_cyc;

  always #4 clk = ~clk;

  rowacc_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .row_size(row_size), .col_size(col_size),
    .busy(busy), .done(done), .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // synchronous memory, one cycle read latency
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_row][rd_col];

  // port monitor
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      if (n_rd < 64) begin rd_cyc[n_rd] = cyc; rd_r[n_rd] = rd_row; rd_c[n_rd] = rd_col; end
      n_rd = n_rd + 1;
    end
    if (wr_en) begin
      if (n_wr < 64) begin wr_cyc[n_wr] = cyc; wr_i[n_wr] = wr_idx; wr_v[n_wr] = wr_data; end
      n_wr = n_wr + 1;
    end
    if (done) begin done_cyc = cyc; n_done = n_done + 1; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0 || n > 8) ? 8 : n;
  endfunction

  task automatic fill(input int seed, input bit big);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (big) mem[r][c] = 32'h7FFF_FF00 + 32'(r * 16 + c);
        else mem[r][c] = 32'((r * 37 + c * 11 + seed) * (((r + c) % 3 == 0) ? -1 : 1));
  endtask

  task automatic clear_log();
    n_rd = 0; n_wr = 0; n_done = 0; done_cyc = -1;
  endtask

  // start a run, optionally poke start/sizes while busy, then check the logs
  task automatic run_case(input int nr, input int nc, input bit poke);
    int er, ec, t, k;
    logic [31:0] s;
    bit ok;
    er = eff(nr); ec = eff(nc);
    @(negedge clk);
    clear_log();
    row_size = 4'(nr); col_size = 4'(nc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rd_en && rd_row == 0 && rd_col == 0 && busy, "R2", "first request",
        {rd_en, busy, rd_row, rd_col}, 8'hC0);
    if (poke) begin
      row_size = 4'd1; col_size = 4'd1; start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (n_done == 0 && t < 300) begin @(negedge clk); t++; end
    chk(t < 300, "R8", "done seen", t, 0);
    @(negedge clk);
    chk(!busy, "R8", "busy low after done", busy, 0);
    repeat (4) @(negedge clk);
    chk(!rd_en && !busy && n_done == 1, poke ? "R9" : "R8", "no rerun / one done",
        n_done, 1);
    chk(n_rd == er * ec, (nr == 0 || nr > 8 || nc == 0 || nc > 8) ? "R7" : "R6",
        "read count", n_rd, er * ec);
    chk(n_wr == er * ec, "R6", "write count", n_wr, er * ec);
    ok = 1;
    for (int i = 0; i < n_rd && i < 64; i++)
      if (rd_r[i] != i / ec || rd_c[i] != i % ec || rd_cyc[i] != rd_cyc[0] + i) ok = 0;
    chk(ok, "R3", "row-major back-to-back reads", ok, 1);
    k = 0;
    for (int r = 0; r < er; r++) begin
      s = '0;
      for (int c = 0; c < ec; c++) begin
        s = s + mem[r][c];
        if (k < n_wr && k < 64) begin
          if (wr_v[k] != s)
            chk(0, "R4", "running sum", $signed(wr_v[k]), $signed(s));
          if (wr_i[k] != r)
            chk(0, "R5", "write slot", wr_i[k], r);
          if (k < n_rd && wr_cyc[k] != rd_cyc[k] + 2)
            chk(0, "R5", "write latency", wr_cyc[k] - rd_cyc[k], 2);
        end
        k++;
      end
    end
    chk(1, "R4", "sum sweep complete", 1, 1);
    if (n_wr > 0 && n_wr <= 64)
      chk(done_cyc == wr_cyc[n_wr - 1] + 1, "R8", "done after last write",
          done_cyc - wr_cyc[n_wr - 1], 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1", "idle after reset",
        {busy, done, rd_en, wr_en}, 0);
  endtask

  task automatic t_partial();  fill(5, 0);  run_case(3, 5, 0);  endtask
  task automatic t_single();   fill(9, 0);  run_case(1, 1, 0);  endtask
  task automatic t_exact8();   fill(2, 0);  run_case(8, 8, 0);  endtask
  task automatic t_zero();     fill(13, 0); run_case(0, 0, 0);  endtask
  task automatic t_oversize(); fill(21, 0); run_case(9, 2, 0);  run_case(2, 12, 0); endtask
  task automatic t_wrap();     fill(0, 1);  run_case(4, 8, 0);  endtask
  task automatic t_ignore();   fill(7, 0);  run_case(3, 4, 1);  endtask
  task automatic t_b2b();      fill(3, 0);  run_case(7, 3, 0);  fill(4, 0); run_case(2, 6, 0); endtask

  initial begin
    clear_log();
    t_reset();
    t_partial();
    t_single();
    t_exact8();
    t_zero();
    t_oversize();
    t_wrap();
    t_ignore();
    t_b2b();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule